// File: doc/BRIEF.md
# SCSI Initiator Information-Phase Sequencer

This block is the initiator-side engine that moves bytes during one information transfer phase of a parallel SCSI bus. When a transfer command starts, it latches the phase shown on the MSG, C/D and I/O lines. The I/O bit decides whether bytes are sent from the FIFO or received into it. Each byte is exchanged with the target using the REQ/ACK handshake. The block drops ATN ahead of the final outgoing message byte. On the final incoming message byte it keeps ACK asserted.

At every fresh REQ the sequencer decides whether the command has finished. The rule used depends on whether the command is DMA or programmed, and on whether the phase is inbound or outbound. If the command has not finished and the target has moved to a different phase, the command ends with a bus-service event. If the command has not finished and the phase is unchanged, the next byte is moved. A pad mode uses the same handshake to exchange filler bytes until the external transfer counter runs out.

The FIFO and the transfer counter live outside this block. The sequencer sees their live values and requests changes through single-cycle pulses. Those pulses are a pop, a push and a counter decrement.

Top module: `scsi_xfer_seq`

## Requirements
- R1: Phase codes {MSG,C/D,I/O} 000, 010 and 110 (data out, command, message out) send: each byte issues one `fifo_pop` pulse. Codes 001, 011 and 111 (data in, status, message in) receive: each byte issues one `fifo_push` pulse. Pop and push are never active in the same cycle.
- R2: `dma_dir` shows 01 (out) or 10 (in) during a byte move of a DMA command, following the send/receive class of R1. It is 00 (none) throughout a non-DMA command.
- R3: ACK rises only in the cycle after REQ was seen high. When sending, the `fifo_pop` for a byte comes before its ACK. ACK is released once REQ is seen low, and it is not asserted while REQ stays low.
- R4: In message out (110), ATN drops in the same cycle as the `fifo_pop` of the final byte. The final byte is the one popped when `fifo_cnt`=1 (non-DMA) or when `cnt_val`=1 (DMA). ATN stays high for the earlier bytes.
- R5: In message in (111), the final byte keeps ACK asserted after REQ falls, and `cmd_done` pulses. For non-DMA every byte is final; for DMA the final byte is the one taken when `cnt_val`=1.
- R6: For a DMA command, a new REQ seen while `cnt_val`=0 and `fifo_cnt`=0 ends the command with `cmd_done`.
- R7: For a non-DMA outbound phase, a new REQ seen while `fifo_cnt`=0 ends the command with `cmd_done`.
- R8: For a non-DMA inbound phase, a new REQ seen while `fifo_cnt`=1 ends the command with `cmd_done`.
- R9: A new REQ that does not meet R6-R8, with a bus phase different from the latched phase, ends the command with `bus_svc` and moves no byte. `cmd_done` and `bus_svc` never pulse together.
- R10: A new REQ that does not meet R6-R8, in the same phase, moves the next byte.
- R11: In pad mode, each REQ gets one ACK handshake, and each release of ACK issues one `cnt_dec`. The command completes when the decrement takes `cnt_val` from 1 to zero. It completes at once, with no handshake, if `cnt_val` is zero at start.
- R12: Under reset, ACK, ATN, all pulses and `busy` are low, and `dma_dir` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer command (accepted when idle) |
| dma_cmd | input | 1 | The command being started is a DMA command |
| pad_cmd | input | 1 | The command being started is a pad command |
| atn_in | input | 1 | ATN level to drive at start |
| bus_req | input | 1 | REQ from target |
| bus_msg | input | 1 | MSG line |
| bus_cd | input | 1 | C/D line |
| bus_io | input | 1 | I/O line (1 = toward initiator) |
| cnt_val | input | CNT_W | Live transfer counter |
| fifo_cnt | input | FIFO_W | Bytes held in the FIFO |
| bus_ack | output | 1 | ACK drive |
| bus_atn | output | 1 | ATN drive |
| fifo_pop | output | 1 | Take one byte from the FIFO onto the bus |
| fifo_push | output | 1 | Store the bus byte into the FIFO |
| cnt_dec | output | 1 | Decrement the transfer counter (pad mode) |
| dma_dir | output | 2 | DMA direction: 00 none, 01 out, 10 in |
| cmd_done | output | 1 | Command complete pulse |
| bus_svc | output | 1 | Phase change ended the command |
| busy | output | 1 | Command in progress |

## Verification
The hardest cases to reach are those where the last-byte rules and the completion rules act at the same REQ as a phase change. Examples are a DMA message-in where only the third byte may hold ACK, and a message-out where ATN must fall exactly with the last pop. The bench contains a behavioural target that raises and drops REQ in answer to ACK. It also models the FIFO level and the counter from the pulses the block emits. After a scripted number of handshakes, the target switches to a new phase, so each table entry drives the block into one precise combination of counter, FIFO level and phase at the deciding REQ.

// File: rtl/sxs_pkg.sv
package sxs_pkg;

    localparam logic [2:0] PH_MSG_OUT = 3'b110;
    localparam logic [2:0] PH_MSG_IN  = 3'b111;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_OUT  = 2'b01,
        DIR_IN   = 2'b10
    } dma_dir_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_SEND_REQ,
        ST_ACK_HOLD,
        ST_WAIT_REQ,
        ST_PAD_REQ,
        ST_PAD_ACK
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic [2:0] phase;
        logic       dma;
        logic       hold_last;
        logic       atn;
        logic       ack;
        logic       pop;
        logic       push;
        logic       dec;
        logic       done;
        logic       svc;
        dma_dir_e   dir;
    } seq_regs_t;

endpackage

// File: rtl/sxs_phase_dec.sv
module sxs_phase_dec (
    input  logic [2:0] phase,
    output logic       inbound,
    output logic       is_msg_out,
    output logic       is_msg_in
);
    import sxs_pkg::*;

    always_comb begin
        inbound    = phase[0];
        is_msg_out = (phase == PH_MSG_OUT);
        is_msg_in  = (phase == PH_MSG_IN);
    end
endmodule

// File: rtl/sxs_last_byte.sv
module sxs_last_byte #(
    parameter int CNT_W  = 16,
    parameter int FIFO_W = 5
) (
    input  logic              dma,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [FIFO_W-1:0] fifo_cnt,
    output logic              last_out,
    output logic              last_in
);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [FIFO_W-1:0] FIFO_ONE = FIFO_W'(1);

    always_comb begin
        last_out = dma ? (cnt_val == CNT_ONE) : (fifo_cnt == FIFO_ONE);
        last_in  = dma ? (cnt_val == CNT_ONE) : 1'b1;
    end
endmodule

// File: rtl/sxs_end_rule.sv
module sxs_end_rule #(
    parameter int CNT_W  = 16,
    parameter int FIFO_W = 5
) (
    input  logic              dma,
    input  logic              inbound,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [FIFO_W-1:0] fifo_cnt,
    output logic              complete
);
    localparam logic [FIFO_W-1:0] FIFO_ONE = FIFO_W'(1);

    logic fifo_empty;
    logic cnt_zero;

    always_comb begin
        fifo_empty = (fifo_cnt == '0);
        cnt_zero   = (cnt_val == '0);
        if (dma)
            complete = cnt_zero && fifo_empty;
        else if (inbound)
            complete = (fifo_cnt == FIFO_ONE);
        else
            complete = fifo_empty;
    end
endmodule

// File: rtl/scsi_xfer_seq.sv
module scsi_xfer_seq #(
    parameter int CNT_W  = 16,
    parameter int FIFO_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dma_cmd,
    input  logic              pad_cmd,
    input  logic              atn_in,
    input  logic              bus_req,
    input  logic              bus_msg,
    input  logic              bus_cd,
    input  logic              bus_io,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [FIFO_W-1:0] fifo_cnt,
    output logic              bus_ack,
    output logic              bus_atn,
    output logic              fifo_pop,
    output logic              fifo_push,
    output logic              cnt_dec,
    output logic [1:0]        dma_dir,
    output logic              cmd_done,
    output logic              bus_svc,
    output logic              busy
);
    import sxs_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    seq_regs_t r_q, r_d;

    logic [2:0] bus_phase;
    logic       lat_inbound, lat_msg_out, lat_msg_in;
    logic       last_out, last_in;
    logic       complete;

    assign bus_phase = {bus_msg, bus_cd, bus_io};

    sxs_phase_dec u_phase (
        .phase      (r_q.phase),
        .inbound    (lat_inbound),
        .is_msg_out (lat_msg_out),
        .is_msg_in  (lat_msg_in)
    );

    sxs_last_byte #(.CNT_W(CNT_W), .FIFO_W(FIFO_W)) u_last (
        .dma      (r_q.dma),
        .cnt_val  (cnt_val),
        .fifo_cnt (fifo_cnt),
        .last_out (last_out),
        .last_in  (last_in)
    );

    sxs_end_rule #(.CNT_W(CNT_W), .FIFO_W(FIFO_W)) u_end (
        .dma      (r_q.dma),
        .inbound  (lat_inbound),
        .cnt_val  (cnt_val),
        .fifo_cnt (fifo_cnt),
        .complete (complete)
    );

    always_comb begin
        r_d      = r_q;
        r_d.pop  = 1'b0;
        r_d.push = 1'b0;
        r_d.dec  = 1'b0;
        r_d.done = 1'b0;
        r_d.svc  = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.phase     = bus_phase;
                    r_d.dma       = dma_cmd;
                    r_d.atn       = atn_in;
                    r_d.ack       = 1'b0;
                    r_d.hold_last = 1'b0;
                    r_d.dir       = DIR_NONE;
                    r_d.state     = pad_cmd ? ST_PAD_REQ : ST_XFER;
                end
            end
            ST_XFER: begin
                if (!lat_inbound) begin
                    r_d.dir = r_q.dma ? DIR_OUT : DIR_NONE;
                    if (fifo_cnt != '0) begin
                        r_d.pop = 1'b1;
                        if (lat_msg_out && last_out)
                            r_d.atn = 1'b0;
                        r_d.hold_last = 1'b0;
                        r_d.state     = ST_SEND_REQ;
                    end
                end else begin
                    r_d.dir = r_q.dma ? DIR_IN : DIR_NONE;
                    if (bus_req) begin
                        r_d.push      = 1'b1;
                        r_d.ack       = 1'b1;
                        r_d.hold_last = lat_msg_in && last_in;
                        r_d.state     = ST_ACK_HOLD;
                    end
                end
            end
            ST_SEND_REQ: begin
                if (bus_req) begin
                    r_d.ack   = 1'b1;
                    r_d.state = ST_ACK_HOLD;
                end
            end
            ST_ACK_HOLD: begin
                if (!bus_req) begin
                    if (r_q.hold_last) begin
                        r_d.done  = 1'b1;
                        r_d.dir   = DIR_NONE;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.ack   = 1'b0;
                        r_d.state = ST_WAIT_REQ;
                    end
                end
            end
            ST_WAIT_REQ: begin
                if (bus_req) begin
                    if (complete) begin
                        r_d.done  = 1'b1;
                        r_d.dir   = DIR_NONE;
                        r_d.state = ST_IDLE;
                    end else if (bus_phase != r_q.phase) begin
                        r_d.svc   = 1'b1;
                        r_d.dir   = DIR_NONE;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_XFER;
                    end
                end
            end
            ST_PAD_REQ: begin
                if (cnt_val == '0) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (bus_req) begin
                    r_d.ack   = 1'b1;
                    r_d.state = ST_PAD_ACK;
                end
            end
            ST_PAD_ACK: begin
                if (!bus_req) begin
                    r_d.ack = 1'b0;
                    r_d.dec = 1'b1;
                    if (cnt_val == CNT_ONE) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_PAD_REQ;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, phase: 3'b000, dma: 1'b0, hold_last: 1'b0,
                     atn: 1'b0, ack: 1'b0, pop: 1'b0, push: 1'b0, dec: 1'b0,
                     done: 1'b0, svc: 1'b0, dir: DIR_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_ack   = r_q.ack;
    assign bus_atn   = r_q.atn;
    assign fifo_pop  = r_q.pop;
    assign fifo_push = r_q.push;
    assign cnt_dec   = r_q.dec;
    assign dma_dir   = r_q.dir;
    assign cmd_done  = r_q.done;
    assign bus_svc   = r_q.svc;
    assign busy      = (r_q.state != ST_IDLE);

    AST_POP_PUSH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_pop && fifo_push)); // R1
    AST_DIR_NONDMA: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !r_q.dma) |-> (dma_dir == DIR_NONE)); // R2
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> $past(bus_req)); // R3
    AST_ATN_DROP_WITH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_atn) && !$past(start)) |-> fifo_pop); // R4
    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && bus_svc)); // R9
    AST_DEC_ON_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dec |-> $fell(bus_ack)); // R11

endmodule

// File: tb/test_scsi_xfer_seq.sv
module test_scsi_xfer_seq;

    localparam int CNT_W  = 16;
    localparam int FIFO_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0, dma_cmd = 1'b0, pad_cmd = 1'b0, atn_in = 1'b0;
    logic              bus_req = 1'b0;
    logic [2:0]        bus_phase = 3'b000;
    logic [CNT_W-1:0]  cnt_val = '0;
    logic [FIFO_W-1:0] fifo_cnt = '0;
    logic              bus_ack, bus_atn, fifo_pop, fifo_push, cnt_dec, cmd_done, bus_svc, busy;
    logic [1:0]        dma_dir;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scsi_xfer_seq #(.CNT_W(CNT_W), .FIFO_W(FIFO_W)) i_scsi_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dma_cmd(dma_cmd), .pad_cmd(pad_cmd),
        .atn_in(atn_in), .bus_req(bus_req), .bus_msg(bus_phase[2]), .bus_cd(bus_phase[1]),
        .bus_io(bus_phase[0]), .cnt_val(cnt_val), .fifo_cnt(fifo_cnt),
        .bus_ack(bus_ack), .bus_atn(bus_atn), .fifo_pop(fifo_pop), .fifo_push(fifo_push),
        .cnt_dec(cnt_dec), .dma_dir(dma_dir), .cmd_done(cmd_done), .bus_svc(bus_svc), .busy(busy)
    );

    typedef struct packed {
        logic [2:0] ph;
        logic       dma;
        logic       pad;
        logic [7:0] f0;
        logic [7:0] c0;
        logic [7:0] treqs;
        logic [2:0] nph;
        logic [7:0] moved;
        logic [1:0] ev;      // 1 = done, 2 = bus service
        logic [1:0] dir;
        logic       ack_end;
        logic       atn_first;
        logic       atn_end;
    } case_t;

    localparam int NCASE = 15;
    localparam case_t CASES [NCASE] = '{
        '{3'b000,1'b0,1'b0,8'd3,8'd0,8'd3, 3'b011,8'd3,2'd1,2'd0,1'b0,1'b1,1'b1}, // R1 R7 R10
        '{3'b000,1'b1,1'b0,8'd4,8'd4,8'd4, 3'b011,8'd4,2'd1,2'd1,1'b0,1'b1,1'b1}, // R2 R6
        '{3'b001,1'b0,1'b0,8'd0,8'd0,8'd1, 3'b011,8'd1,2'd1,2'd0,1'b0,1'b1,1'b1}, // R8
        '{3'b001,1'b1,1'b0,8'd0,8'd3,8'd3, 3'b011,8'd3,2'd1,2'd2,1'b0,1'b1,1'b1}, // R2 R6
        '{3'b010,1'b0,1'b0,8'd6,8'd0,8'd6, 3'b001,8'd6,2'd1,2'd0,1'b0,1'b1,1'b1}, // R1 R7
        '{3'b000,1'b0,1'b0,8'd3,8'd0,8'd1, 3'b001,8'd1,2'd2,2'd0,1'b0,1'b1,1'b1}, // R9
        '{3'b001,1'b1,1'b0,8'd0,8'd5,8'd2, 3'b011,8'd2,2'd2,2'd2,1'b0,1'b1,1'b1}, // R9
        '{3'b011,1'b0,1'b0,8'd0,8'd0,8'd1, 3'b111,8'd1,2'd1,2'd0,1'b0,1'b1,1'b1}, // R8
        '{3'b111,1'b0,1'b0,8'd0,8'd0,8'd1, 3'b011,8'd1,2'd1,2'd0,1'b1,1'b1,1'b1}, // R5
        '{3'b111,1'b1,1'b0,8'd0,8'd3,8'd3, 3'b011,8'd3,2'd1,2'd2,1'b1,1'b1,1'b1}, // R5
        '{3'b110,1'b0,1'b0,8'd2,8'd0,8'd2, 3'b011,8'd2,2'd1,2'd0,1'b0,1'b1,1'b0}, // R4
        '{3'b110,1'b1,1'b0,8'd3,8'd3,8'd3, 3'b011,8'd3,2'd1,2'd1,1'b0,1'b1,1'b0}, // R4
        '{3'b110,1'b0,1'b0,8'd1,8'd0,8'd1, 3'b011,8'd1,2'd1,2'd0,1'b0,1'b0,1'b0}, // R4
        '{3'b000,1'b0,1'b1,8'd0,8'd3,8'd99,3'b000,8'd3,2'd1,2'd0,1'b0,1'b1,1'b1}, // R11
        '{3'b000,1'b0,1'b1,8'd0,8'd0,8'd99,3'b000,8'd0,2'd1,2'd0,1'b0,1'b1,1'b1}  // R11
    };

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input int k);
        case_t c;
        int moved, ev, reqs, fq, cq, dsee, af;
        bit afs;
        c = CASES[k];
        moved = 0; ev = 0; reqs = 0; dsee = 0; af = 1; afs = 0;
        fq = int'(c.f0); cq = int'(c.c0);
        @(negedge clk);
        bus_phase = c.ph; bus_req = 1'b1; dma_cmd = c.dma; pad_cmd = c.pad; atn_in = 1'b1;
        fifo_cnt = FIFO_W'(fq); cnt_val = CNT_W'(cq); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 400 && ev == 0; t++) begin
            if (fifo_pop) begin
                fq--; if (c.dma) cq--;
                moved++; dsee = int'(dma_dir);
                if (!afs) begin af = int'(bus_atn); afs = 1; end
            end
            if (fifo_push) begin
                if (c.dma) cq--; else fq++;
                moved++; dsee = int'(dma_dir);
                if (!afs) begin af = int'(bus_atn); afs = 1; end
            end
            if (cnt_dec) begin cq--; moved++; end
            if (cmd_done) ev = 1;
            else if (bus_svc) ev = 2;
            if (ev == 0) begin
                if (bus_req && bus_ack) begin
                    bus_req = 1'b0; reqs++;
                end else if (!bus_req && !bus_ack) begin
                    if (reqs == int'(c.treqs)) bus_phase = c.nph;
                    bus_req = 1'b1;
                end
            end
            fifo_cnt = FIFO_W'(fq); cnt_val = CNT_W'(cq);
            if (ev == 0) @(negedge clk);
        end
        check(moved, int'(c.moved), $sformatf("case %0d bytes moved R1 R10 R11", k));
        check(ev, int'(c.ev), $sformatf("case %0d ending event R6 R7 R8 R9", k));
        check(dsee, int'(c.dir), $sformatf("case %0d dma_dir R2", k));
        check(int'(bus_ack), int'(c.ack_end), $sformatf("case %0d ACK at end R5", k));
        check(af, int'(c.atn_first), $sformatf("case %0d ATN at first byte R4", k));
        check(int'(bus_atn), int'(c.atn_end), $sformatf("case %0d ATN at end R4", k));
        @(negedge clk);
        bus_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int popped;
        // R12: reset state
        repeat (3) @(negedge clk);
        check(int'(bus_ack), 0, "reset ACK R12");
        check(int'(bus_atn), 0, "reset ATN R12");
        check(int'(fifo_pop | fifo_push | cnt_dec), 0, "reset pulses R12");
        check(int'(cmd_done | bus_svc), 0, "reset events R12");
        check(int'(busy), 0, "reset busy R12");
        check(int'(dma_dir), 0, "reset dma_dir R12");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < NCASE; k++) run_case(k);

        // R3: send path holds ACK off until REQ, pop comes first
        @(negedge clk);
        bus_phase = 3'b000; bus_req = 1'b0; dma_cmd = 1'b0; pad_cmd = 1'b0; atn_in = 1'b0;
        fifo_cnt = FIFO_W'(2); cnt_val = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        popped = 0;
        for (int t = 0; t < 5; t++) begin
            if (fifo_pop) begin popped++; fifo_cnt = FIFO_W'(1); end
            @(negedge clk);
        end
        check(popped, 1, "pop before REQ R3");
        check(int'(bus_ack), 0, "no ACK without REQ R3");
        bus_req = 1'b1;
        @(negedge clk);
        check(int'(bus_ack), 1, "ACK one cycle after REQ R3");
        bus_req = 1'b0;
        @(negedge clk);
        check(int'(bus_ack), 0, "ACK released after REQ low R3");
        bus_phase = 3'b001; bus_req = 1'b1;
        @(negedge clk);
        check(int'(bus_svc), 1, "phase change with bytes left R9");
        check(int'(cmd_done), 0, "no done on phase change R9");
        bus_req = 1'b0;
        repeat (2) @(negedge clk);
        check(int'(busy), 0, "idle after bus service R9");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc == 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule